// File: doc/BRIEF.md
# Per-Select Memory Strobe Timing Generator

This block produces the three active-low control strobes of an external memory access: a read enable, a write enable and an address-latch strobe. When an access starts, the block latches the timing word of the addressed chip-select. It then runs a cycle counter from zero. Each strobe goes low and back high at counts taken from that word. A strobe may instead be moved half a functional-clock period later. In that case it is taken from a falling-edge copy of its rising-edge register.

The read strobe responds only to reads and the write strobe only to writes. The address-latch strobe runs in both directions. For devices that share address and data pins, an address-drive enable stays high from the start of the access until the data strobe's assertion count is reached. The access ends with a one-cycle done pulse when the counter reaches the cycle time for the current direction. Until that pulse, further start requests are ignored.

Top module: `strobe_timing_gen`

## Requirements
- R1: While reset is high, and after it, until an access starts, the three strobes are high, and done and address-drive are low.
- R2: The edge that samples start_i is E0, and the following rising edges are E1, E2 and so on. On a read, with rising-edge timing, the read strobe is low from edge E(on+1) until edge E(off+1), where on and off are the read assertion and deassertion counts.
- R3: On a write, the write strobe follows the same rule as R2, using the write assertion and deassertion counts.
- R4: The read strobe never goes low during a write, and the write strobe never goes low during a read, so the two are never low together.
- R5: The address-latch strobe follows the same rule as R2 with its own counts, on both reads and writes.
- R6: When a strobe's half-cycle bit is set, both of its edges occur at the falling clock edge that follows the rising edge given in R2, R3 or R5.
- R7: If a strobe's assertion count is greater than or equal to its deassertion count, that strobe stays high for the whole access.
- R8: done_o is high for exactly one cycle, after edge E(cyc+1). Here cyc is the read cycle time for a read and the write cycle time for a write.
- R9: A start_i pulse received while an access is running is ignored. It causes no second access and no second done pulse.
- R10: The timing word is latched at E0. Changes to cfg_i during the access have no effect on that access.
- R11: For a multiplexed access, addr_drive_o is high after edge Ek when k-1 <= cyc and k-1 < on_dir. Here on_dir is the assertion count of the read strobe (for reads) or of the write strobe (for writes). For non-multiplexed accesses it is always low.
- R12: Each of the NUM_CS chip-selects uses only its own timing word, chosen by cs_i at start.
- R13: The word for chip-select i is cfg_i[i*40 +: 40]. Its fields, from the least significant bit upward, are: read on [3:0], read off [8:4], write on [12:9], write off [17:13], latch on [21:18], latch off [26:22], read cycle [31:27], write cycle [36:32], read half-cycle [37], write half-cycle [38], latch half-cycle [39]. wr_i=1 selects a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access start request, sampled when idle |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| mux_i | input | 1 | Target shares address and data pins |
| cs_i | input | CS_W | Chip-select index |
| cfg_i | input | NUM_CS*40 | Timing words, one per chip-select |
| oe_n_o | output | 1 | Read enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| adv_n_o | output | 1 | Address-latch strobe, active low |
| addr_drive_o | output | 1 | Drive address on shared bus |
| done_o | output | 1 | One-cycle access-complete pulse |

## Verification
Some rules are checked by the assertions on every cycle:
- the read and write strobes are never low together;
- done lasts exactly one cycle;
- the counter never passes the latched cycle time;
- the latched word stays constant while an access runs;
- the address drive is off whenever the read strobe is low;
- a strobe whose assertion count is not below its deassertion count stays high.

The directed scenarios check what no single-cycle property can show. They confirm the exact edges at which each strobe goes low and high, in both halves of each cycle, including the half-cycle shift. They also confirm that a start during an access and a change to the timing word during an access are both ignored, and that each chip-select gets its own timing.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int CYC_W = 5;

  typedef struct packed {
    logic             adv_xd;
    logic             wr_xd;
    logic             rd_xd;
    logic [CYC_W-1:0] wr_cyc;
    logic [CYC_W-1:0] rd_cyc;
    logic [OFF_W-1:0] adv_off;
    logic [ON_W-1:0]  adv_on;
    logic [OFF_W-1:0] wr_off;
    logic [ON_W-1:0]  wr_on;
    logic [OFF_W-1:0] rd_off;
    logic [ON_W-1:0]  rd_on;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);
endpackage

// File: rtl/stg_sequencer.sv
module stg_sequencer
  import stg_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    wr_i,
  input  logic                    mux_i,
  input  logic [CS_W-1:0]         cs_i,
  input  logic [NUM_CS*CFG_W-1:0] cfg_flat_i,
  output logic                    busy_o,
  output logic                    wr_o,
  output logic                    mux_o,
  output logic [CYC_W-1:0]        cnt_o,
  output cs_cfg_t                 cfg_o,
  output logic                    done_o
);
  cs_cfg_t          cfg_arr [NUM_CS];
  cs_cfg_t          cfg_q;
  logic             busy_q, wr_q, mux_q, done_q;
  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] cyc_lim;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign cfg_arr[g] = cfg_flat_i[g*CFG_W +: CFG_W];
  end

  assign cyc_lim = wr_q ? cfg_q.wr_cyc : cfg_q.rd_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      mux_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        cfg_q  <= cfg_arr[cs_i];
        wr_q   <= wr_i;
        mux_q  <= mux_i;
      end else if (busy_q) begin
        if (cnt_q == cyc_lim) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign wr_o   = wr_q;
  assign mux_o  = mux_q;
  assign cnt_o  = cnt_q;
  assign cfg_o  = cfg_q;
  assign done_o = done_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= cyc_lim)); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q)); // R10
endmodule

// File: rtl/stg_strobe.sv
module stg_strobe #(
  parameter int ON_W  = 4,
  parameter int OFF_W = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             xd_i,
  output logic             strobe_n_o
);
  logic [CNT_W-1:0] on_x, off_x;
  logic             active;
  logic             pos_q, neg_q;

  assign on_x   = CNT_W'(on_i);
  assign off_x  = CNT_W'(off_i);
  assign active = en_i && (on_x < off_x) && (cnt_i >= on_x) && (cnt_i < off_x);

  always_ff @(posedge clk) begin
    if (rst) pos_q <= 1'b1;
    else     pos_q <= ~active;
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b1;
    else     neg_q <= pos_q;
  end

  assign strobe_n_o = xd_i ? neg_q : pos_q;

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (en_i && (on_x >= off_x)) |=> pos_q); // R7
endmodule

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen
  import stg_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    wr_i,
  input  logic                    mux_i,
  input  logic [CS_W-1:0]         cs_i,
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  output logic                    oe_n_o,
  output logic                    we_n_o,
  output logic                    adv_n_o,
  output logic                    addr_drive_o,
  output logic                    done_o
);
  localparam int NSTR = 3;

  logic             busy, wr_q, mux_q;
  logic [CYC_W-1:0] cnt;
  cs_cfg_t          cfg_q;
  logic             addr_q;

  logic [NSTR-1:0]  str_en, str_xd, str_n;
  logic [ON_W-1:0]  str_on  [NSTR];
  logic [OFF_W-1:0] str_off [NSTR];

  stg_sequencer #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_i(wr_i), .mux_i(mux_i),
    .cs_i(cs_i), .cfg_flat_i(cfg_i), .busy_o(busy), .wr_o(wr_q),
    .mux_o(mux_q), .cnt_o(cnt), .cfg_o(cfg_q), .done_o(done_o)
  );

  // lane 0 read, lane 1 write, lane 2 address latch
  always_comb begin
    str_en[0]  = busy && !wr_q;
    str_on[0]  = cfg_q.rd_on;
    str_off[0] = cfg_q.rd_off;
    str_xd[0]  = cfg_q.rd_xd;
    str_en[1]  = busy && wr_q;
    str_on[1]  = cfg_q.wr_on;
    str_off[1] = cfg_q.wr_off;
    str_xd[1]  = cfg_q.wr_xd;
    str_en[2]  = busy;
    str_on[2]  = cfg_q.adv_on;
    str_off[2] = cfg_q.adv_off;
    str_xd[2]  = cfg_q.adv_xd;
  end

  for (genvar g = 0; g < NSTR; g++) begin : g_lane
    stg_strobe #(.ON_W(ON_W), .OFF_W(OFF_W), .CNT_W(CYC_W)) u_str (
      .clk(clk), .rst(rst), .en_i(str_en[g]), .cnt_i(cnt),
      .on_i(str_on[g]), .off_i(str_off[g]), .xd_i(str_xd[g]),
      .strobe_n_o(str_n[g])
    );
  end

  assign oe_n_o  = str_n[0];
  assign we_n_o  = str_n[1];
  assign adv_n_o = str_n[2];

  always_ff @(posedge clk) begin
    if (rst) addr_q <= 1'b0;
    else     addr_q <= busy && mux_q &&
                       (cnt < CYC_W'(wr_q ? cfg_q.wr_on : cfg_q.rd_on));
  end
  assign addr_drive_o = addr_q;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n_o && !we_n_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_ADDR_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> !addr_drive_o); // R11
endmodule

// File: tb/strobe_timing_gen_tb.sv
module strobe_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 8;
  localparam int CFG_W = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr = 1'b0, mux = 1'b0;
  logic [2:0] cs = '0;
  logic [NUM_CS*CFG_W-1:0] cfg = '0;
  logic oe_n, we_n, adv_n, addr_drv, done;
  int checks = 0, errors = 0;

  int rd_on[NUM_CS], rd_off[NUM_CS], wr_on[NUM_CS], wr_off[NUM_CS];
  int adv_on[NUM_CS], adv_off[NUM_CS], rd_cyc[NUM_CS], wr_cyc[NUM_CS];
  bit rd_xd[NUM_CS], wr_xd[NUM_CS], adv_xd[NUM_CS];

  strobe_timing_gen #(.NUM_CS(NUM_CS)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .wr_i(wr), .mux_i(mux), .cs_i(cs),
    .cfg_i(cfg), .oe_n_o(oe_n), .we_n_o(we_n), .adv_n_o(adv_n),
    .addr_drive_o(addr_drv), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R13 field layout
  function automatic logic [CFG_W-1:0] pack(int i);
    return {adv_xd[i], wr_xd[i], rd_xd[i], 5'(wr_cyc[i]), 5'(rd_cyc[i]),
            5'(adv_off[i]), 4'(adv_on[i]), 5'(wr_off[i]), 4'(wr_on[i]),
            5'(rd_off[i]), 4'(rd_on[i])};
  endfunction

  task automatic load_cfg();
    for (int i = 0; i < NUM_CS; i++) cfg[i*CFG_W +: CFG_W] = pack(i);
  endtask

  task automatic set_cs(int i, int ron, int roff, int won, int woff, int aon,
                        int aoff, int rc, int wc, bit rx, bit wx, bit ax);
    rd_on[i] = ron; rd_off[i] = roff; wr_on[i] = won; wr_off[i] = woff;
    adv_on[i] = aon; adv_off[i] = aoff; rd_cyc[i] = rc; wr_cyc[i] = wc;
    rd_xd[i] = rx; wr_xd[i] = wx; adv_xd[i] = ax;
    load_cfg();
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit win(int on, int off, int k);
    return (on < off) && (k >= on + 1) && (k <= off);
  endfunction

  // Runs one access and checks every output in both halves of each cycle.
  task automatic run_access(int c, bit w, bit m, int inj_k, int chg_k, string req);
    int ron = rd_on[c], roff = rd_off[c], won = wr_on[c], woff = wr_off[c];
    int aon = adv_on[c], aoff = adv_off[c];
    int cyc = w ? wr_cyc[c] : rd_cyc[c];
    bit rx = rd_xd[c], wx = wr_xd[c], ax = adv_xd[c];
    @(negedge clk); cs = 3'(c); wr = w; mux = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= cyc + 4; k++) begin
      bit rc_ = !w && win(ron, roff, k), rp = !w && win(ron, roff, k-1);
      bit wc_ = w && win(won, woff, k),  wp = w && win(won, woff, k-1);
      bit ac = win(aon, aoff, k),        ap = win(aon, aoff, k-1);
      bit dn = (k == cyc + 1);
      bit ad = m && (k - 1 <= cyc) && (k - 1 < (w ? won : ron));
      @(posedge clk); #2;
      chk(req, "oe_n early", oe_n, ~(rx ? rp : rc_));
      chk(req, "we_n early", we_n, ~(wx ? wp : wc_));
      chk(req, "adv_n early", adv_n, ~(ax ? ap : ac));
      chk(req, "done early", done, dn);
      chk(req, "addr_drive", addr_drv, ad);
      start = 1'b0;
      if (k == chg_k) begin
        set_cs(c, 0, 15, 0, 15, 0, 15, 3, 3, 0, 0, 0); // R10 late change
      end
      #5;
      chk(req, "oe_n late", oe_n, ~rc_);
      chk(req, "we_n late", we_n, ~wc_);
      chk(req, "adv_n late", adv_n, ~ac);
      chk(req, "done late", done, dn);
      if (k == inj_k) begin
        start = 1'b1; cs = 3'((c + 1) % NUM_CS); wr = ~w; // R9 start while busy
      end
    end
  endtask

  task automatic t_reset(); // R1
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "oe_n", oe_n, 1'b1); chk("R1", "we_n", we_n, 1'b1);
    chk("R1", "adv_n", adv_n, 1'b1); chk("R1", "done", done, 1'b0);
    chk("R1", "addr_drive", addr_drv, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R1", "oe_n idle", oe_n, 1'b1); chk("R1", "done idle", done, 1'b0);
  endtask

  task automatic t_read(); // R2 R5 R8 R4 R13
    set_cs(0, 2, 6, 1, 5, 0, 2, 9, 8, 0, 0, 0);
    run_access(0, 1'b0, 1'b0, 0, 0, "R2_R5_R8");
  endtask

  task automatic t_write(); // R3 R4
    set_cs(3, 3, 7, 2, 6, 1, 3, 10, 9, 0, 0, 0);
    run_access(3, 1'b1, 1'b0, 0, 0, "R3_R4");
  endtask

  task automatic t_extra(); // R6
    set_cs(5, 1, 4, 2, 5, 0, 2, 7, 8, 1, 1, 1);
    run_access(5, 1'b0, 1'b0, 0, 0, "R6_rd");
    run_access(5, 1'b1, 1'b0, 0, 0, "R6_wr");
  endtask

  task automatic t_degen(); // R7
    set_cs(2, 5, 5, 6, 2, 3, 3, 8, 8, 0, 0, 0);
    run_access(2, 1'b0, 1'b0, 0, 0, "R7_rd");
    run_access(2, 1'b1, 1'b0, 0, 0, "R7_wr");
  endtask

  task automatic t_busy(); // R9
    set_cs(0, 2, 6, 1, 5, 0, 2, 9, 8, 0, 0, 0);
    set_cs(1, 0, 1, 0, 1, 0, 1, 2, 2, 0, 0, 0);
    run_access(0, 1'b0, 1'b0, 3, 0, "R9");
  endtask

  task automatic t_cfg(); // R10
    set_cs(0, 2, 6, 1, 5, 0, 2, 9, 8, 0, 0, 0);
    run_access(0, 1'b0, 1'b0, 0, 2, "R10");
  endtask

  task automatic t_mux(); // R11
    set_cs(4, 4, 8, 3, 7, 0, 2, 10, 9, 0, 0, 0);
    run_access(4, 1'b0, 1'b1, 0, 0, "R11_rd");
    run_access(4, 1'b1, 1'b1, 0, 0, "R11_wr");
    run_access(4, 1'b0, 1'b0, 0, 0, "R11_nomux");
  endtask

  task automatic t_cs_sel(); // R12
    for (int i = 0; i < NUM_CS; i++) begin
      set_cs(i, i % 4, i % 4 + 2 + i % 3, (i + 1) % 4, (i + 1) % 4 + 3,
             i % 2, i % 2 + 1 + i % 3, i % 4 + 2 + i % 3 + 2 + i % 2,
             (i + 1) % 4 + 5 + i % 3, i[0], i[1], i[2]);
    end
    run_access(7, 1'b0, 1'b1, 0, 0, "R12_cs7");
    run_access(1, 1'b0, 1'b0, 0, 0, "R12_cs1");
    run_access(6, 1'b1, 1'b1, 0, 0, "R12_cs6");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_read();
    t_write();
    t_extra();
    t_degen();
    t_busy();
    t_cfg();
    t_mux();
    t_cs_sel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule